// File: doc/BRIEF.md
# Indirect Framer Configuration Sequencer

This block brings a line framer into a known state after power-up. The framer's internal registers are not directly addressable: each access first loads a register index into an address register, then writes or reads a separate data register. A single start pulse makes the sequencer issue the whole bring-up routine on its own through a small request/acknowledge access port. A management-bus bridge outside this block carries each access to the framer.

The routine has three phases, always in the same order. First, indices 0 to 20 are each loaded with zero. Second, three configuration values are written: 0x05 to index 1, which enables the serial and transmit bits, then 0x80 to index 5, which enables the operating mode, then 0x30 to index 14, which turns on the receive and transmit clock generators. Third, every index from 0 to 20 is read once and the value is thrown away. This read clears the framer's counters and sticky status bits. The `busy` output is high while the routine runs. `done` pulses once when it ends.

Top module: `fcfg_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`, `done` and `acc_req` all low.
- R2: A `start` sampled high while idle sets `busy` from the next cycle. The complete run is then issued, which is 90 accesses.
- R3: Every framer access is a pair. First comes an index load (`acc_op` = 2'b00, index on `acc_wdata`). Then comes either a data write (`acc_op` = 2'b01, value on `acc_wdata`) or a data read (`acc_op` = 2'b10).
- R4: The first phase loads indices 0, 1, …, 20 in ascending order, and writes 0x00 after each load.
- R5: The second phase writes index 1 = 0x05, then index 5 = 0x80, then index 14 = 0x30, in that order. After a full run the register file holds those three values, and zero at every other index from 0 to 20.
- R6: The third phase loads indices 0, 1, …, 20 in ascending order, and does one data read after each load. The run therefore reads every one of the 21 registers.
- R7: `acc_req` stays high, with `acc_op` and `acc_wdata` unchanged, until `acc_ack` is seen with it. The cycle after an acknowledged access, `acc_req` is low. At most one access is open at a time.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the acknowledge of the final read, and `busy` is low in it.
- R9: A `start` pulse that arrives while `busy` is high has no effect. The run still issues 90 accesses and one `done`.
- R10: A reset during a run abandons it and returns to idle. A later `start` runs the full sequence from its first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to run the routine |
| busy | output | 1 | Routine in progress |
| done | output | 1 | One-cycle pulse when the routine completes |
| acc_req | output | 1 | Access request to the register port |
| acc_op | output | 2 | 00 index load, 01 data write, 10 data read |
| acc_wdata | output | DW (8) | Index for a load, value for a data write |
| acc_ack | input | 1 | Access completed by the port |

## Verification
The bench runs the routine with different acknowledge latencies, including zero wait. A design that drops a request early, or changes it before the acknowledge, would corrupt or skip an access. It fires a stray start mid-run: a sequencer that restarted would show more than 90 accesses or two done pulses. It checks that done appears exactly one cycle after the last read is acknowledged, and never alongside busy. A design off by one at a phase boundary would show this as a missing or a repeated index 20. A reset in the middle of a run must leave a later start to begin again at index 0, not resume where it stopped.

// File: rtl/fcfg_pkg.sv
// Shared types and the fixed programming list for the framer
// configuration sequencer. Assumes data width of at least 8 bits.
package fcfg_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WDATA = 2'b01,
        OP_RDATA = 2'b10
    } acc_op_e;

    typedef enum logic [1:0] {
        PH_ZERO  = 2'b00,
        PH_PROG  = 2'b01,
        PH_SWEEP = 2'b10
    } phase_e;

    localparam int PROG_N = 3;

    // Framer index of the k-th programming write.
    function automatic logic [7:0] prog_index(input logic [1:0] k);
        case (k)
            2'd0:    return 8'd1;
            2'd1:    return 8'd5;
            default: return 8'd14;
        endcase
    endfunction

    // Value of the k-th programming write.
    function automatic logic [7:0] prog_value(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h05;
            2'd1:    return 8'h80;
            default: return 8'h30;
        endcase
    endfunction

endpackage

// File: rtl/fcfg_step.sv
// Step decoder: turns (phase, index, half) into the access to issue.
// Assumes IW >= 2 so the programming list index fits in idx[1:0].
module fcfg_step
    import fcfg_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 21,
    parameter int IW   = $clog2(NREG)
) (
    input  phase_e          phase,
    input  logic [IW-1:0]   idx,
    input  logic            half,
    output acc_op_e         op,
    output logic [DW-1:0]   wdata,
    output logic            last
);

    logic [DW-1:0] target;

    // Decode the access: index load on the first half, data op on the second.
    always_comb begin
        target = (phase == PH_PROG) ? DW'(prog_index(idx[1:0])) : DW'(idx);
        last   = (phase == PH_PROG) ? (idx == IW'(PROG_N - 1))
                                    : (idx == IW'(NREG - 1));
        if (!half) begin
            op    = OP_ADDR;
            wdata = target;
        end else if (phase == PH_SWEEP) begin
            op    = OP_RDATA;
            wdata = '0;
        end else begin
            op    = OP_WDATA;
            wdata = (phase == PH_PROG) ? DW'(prog_value(idx[1:0])) : '0;
        end
    end

endmodule

// File: rtl/fcfg_access.sv
// Access engine: holds one request on the port until acknowledged.
// Assumes the port acknowledges with acc_ack while req is high.
module fcfg_access
    import fcfg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  acc_op_e       op_in,
    input  logic [DW-1:0] data_in,
    input  logic          ack,
    output logic          req,
    output acc_op_e       op,
    output logic [DW-1:0] data,
    output logic          complete
);

    // Launch a request when idle, retire it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            op   <= OP_ADDR;
            data <= '0;
        end else if (req && ack) begin
            req <= 1'b0;
        end else if (!req && issue) begin
            req  <= 1'b1;
            op   <= op_in;
            data <= data_in;
        end
    end

    // Completion strobe for the sequencer.
    assign complete = req && ack;

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> req && $stable(op) && $stable(data))
        else $error("R7 request changed before acknowledge");

    a_r7_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack |=> !req)
        else $error("R7 request not released after acknowledge");

endmodule

// File: rtl/fcfg_seq.sv
// Framer configuration sequencer top: zero-fill, program, read-clear,
// each access an index load followed by a data access.
// Assumes start is a clean synchronous pulse; rst_n is synchronous.
module fcfg_seq
    import fcfg_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          acc_req,
    output logic [1:0]    acc_op,
    output logic [DW-1:0] acc_wdata,
    input  logic          acc_ack
);

    localparam int IW = $clog2(NREG);

    logic          run_q;
    logic          done_q;
    phase_e        phase_q;
    logic [IW-1:0] idx_q;
    logic          half_q;

    acc_op_e       step_op;
    logic [DW-1:0] step_data;
    logic          step_last;
    acc_op_e       port_op;
    logic          complete;

    fcfg_step #(.DW(DW), .NREG(NREG), .IW(IW)) u_step (
        .phase (phase_q),
        .idx   (idx_q),
        .half  (half_q),
        .op    (step_op),
        .wdata (step_data),
        .last  (step_last)
    );

    fcfg_access #(.DW(DW)) u_access (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (run_q),
        .op_in    (step_op),
        .data_in  (step_data),
        .ack      (acc_ack),
        .req      (acc_req),
        .op       (port_op),
        .data     (acc_wdata),
        .complete (complete)
    );

    // Walk phases and indices; advance one half-step per completed access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            done_q  <= 1'b0;
            phase_q <= PH_ZERO;
            idx_q   <= '0;
            half_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!run_q && start) begin
                run_q   <= 1'b1;
                phase_q <= PH_ZERO;
                idx_q   <= '0;
                half_q  <= 1'b0;
            end else if (run_q && complete) begin
                if (!half_q) begin
                    half_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                    if (step_last) begin
                        idx_q <= '0;
                        case (phase_q)
                            PH_ZERO: phase_q <= PH_PROG;
                            PH_PROG: phase_q <= PH_SWEEP;
                            default: begin
                                run_q  <= 1'b0;
                                done_q <= 1'b1;
                            end
                        endcase
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            end
        end
    end

    // Drive outputs.
    assign busy   = run_q;
    assign done   = done_q;
    assign acc_op = port_op;

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R8 done longer than one cycle");

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy))
        else $error("R8 done while busy");

    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(acc_req && acc_ack))
        else $error("R8 done without a preceding acknowledge");

    a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> busy)
        else $error("R2 request while idle");

    a_r3_legal_op: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |-> acc_op != 2'b11)
        else $error("R3 illegal access code");

endmodule

// File: tb/sim_fcfg_seq.sv
module sim_fcfg_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int NREG = 21;
    localparam int NACC = 4 * NREG + 6;
    localparam int NVEC = 4;
    localparam int VEC_LAT   [NVEC] = '{0, 1, 3, 2};
    localparam bit VEC_STRAY [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, acc_req, acc_ack;
    logic [1:0]    acc_op;
    logic [DW-1:0] acc_wdata;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // Port model state
    int            cur_lat = 0;
    int            wcnt = 0;
    int            nlog = 0;
    int            done_cnt = 0;
    int            proto_err = 0;
    int            done_err = 0;
    logic [1:0]    log_op   [128];
    logic [DW-1:0] log_data [128];
    logic [DW-1:0] regs  [NREG];
    bit            latch [NREG];
    int            cur_addr = 0;
    logic          prev_req = 1'b0, prev_ack = 1'b0;
    logic [1:0]    prev_op = '0;
    logic [DW-1:0] prev_data = '0;

    fcfg_seq #(.DW(DW), .NREG(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .acc_req(acc_req), .acc_op(acc_op), .acc_wdata(acc_wdata), .acc_ack(acc_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial acc_ack = 1'b0;

    // Register-port model and protocol monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            acc_ack  = 1'b0;
            wcnt     = 0;
            prev_req = 1'b0;
            prev_ack = 1'b0;
        end else begin
            if (prev_req && !prev_ack &&
                (!acc_req || acc_op != prev_op || acc_wdata != prev_data))
                proto_err++;
            if (prev_ack && acc_req) proto_err++;
            if (done) begin
                done_cnt++;
                if (!(prev_ack && nlog == NACC)) done_err++;
                if (busy) done_err++;
            end
            prev_req  = acc_req;
            prev_op   = acc_op;
            prev_data = acc_wdata;
            if (acc_ack) begin
                acc_ack = 1'b0;
            end else if (acc_req) begin
                if (wcnt >= cur_lat) begin
                    acc_ack = 1'b1;
                    wcnt = 0;
                    if (nlog < 128) begin
                        log_op[nlog]   = acc_op;
                        log_data[nlog] = acc_wdata;
                    end
                    nlog++;
                    if (acc_op == 2'b00) cur_addr = int'(acc_wdata);
                    else if (cur_addr < NREG) begin
                        if (acc_op == 2'b01) regs[cur_addr] = acc_wdata;
                        else latch[cur_addr] = 1'b0;
                    end
                end else begin
                    wcnt++;
                end
            end
            prev_ack = acc_ack;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_op(input int k);
        if (k % 2 == 0) return 0;
        return (k >= 2 * NREG + 6) ? 2 : 1;
    endfunction

    function automatic int exp_data(input int k);
        int j;
        if (k < 2 * NREG) return (k % 2 == 0) ? k / 2 : 0;
        if (k < 2 * NREG + 6) begin
            j = (k - 2 * NREG) / 2;
            if (k % 2 == 0) return (j == 0) ? 1 : (j == 1) ? 5 : 14;
            return (j == 0) ? 8'h05 : (j == 1) ? 8'h80 : 8'h30;
        end
        return (k % 2 == 0) ? (k - 2 * NREG - 6) / 2 : 0;
    endfunction

    task automatic pulse_start();
        @(negedge clk); #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
    endtask

    task automatic clear_model(input int lat);
        nlog = 0; done_cnt = 0; proto_err = 0; done_err = 0;
        cur_lat = lat;
        for (int i = 0; i < NREG; i++) begin
            regs[i]  = 8'hAA;
            latch[i] = 1'b1;
        end
    endtask

    // One full run with a given acknowledge latency, optionally with a stray start.
    task automatic run_seq(input int lat, input bit stray);
        int e_zero, e_prog, e_sweep, e_pair, e_reg, lat_left;
        clear_model(lat);
        pulse_start();
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (stray) begin
            wait (nlog >= 50);
            pulse_start();
        end
        for (int t = 0; t < 5000 && done_cnt == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        e_zero = 0; e_prog = 0; e_sweep = 0; e_pair = 0; e_reg = 0; lat_left = 0;
        for (int k = 0; k < NACC && k < nlog; k++) begin
            if ((k % 2 == 0) != (log_op[k] == 2'b00)) e_pair++;
            if (int'(log_op[k]) != exp_op(k) ||
                (exp_op(k) != 2 && int'(log_data[k]) != exp_data(k))) begin
                if (k < 2 * NREG) e_zero++;
                else if (k < 2 * NREG + 6) e_prog++;
                else e_sweep++;
            end
        end
        for (int i = 0; i < NREG; i++) begin
            if (regs[i] != ((i == 1) ? 8'h05 : (i == 5) ? 8'h80 : (i == 14) ? 8'h30 : 8'h00))
                e_reg++;
            if (latch[i]) lat_left++;
        end
        chk(nlog == NACC, stray ? "R9 access count with stray start" : "R2 access count",
            nlog, NACC);
        chk(done_cnt == 1, stray ? "R9 done count with stray start" : "R8 done count",
            done_cnt, 1);
        chk(e_pair == 0, "R3 index load before each data access", e_pair, 0);
        chk(e_zero == 0, "R4 zero-fill order", e_zero, 0);
        chk(e_prog == 0, "R5 programming order", e_prog, 0);
        chk(e_reg == 0, "R5 final register contents", e_reg, 0);
        chk(e_sweep == 0 && lat_left == 0, "R6 read sweep", e_sweep + lat_left, 0);
        chk(proto_err == 0, "R7 handshake", proto_err, 0);
        chk(done_err == 0, "R8 done timing", done_err, 0);
        chk(busy == 1'b0 && acc_req == 1'b0, "R8 idle after done", int'(busy), 0);
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && acc_req == 1'b0, "R1 reset state",
            int'({busy, done, acc_req}), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && acc_req == 1'b0, "R1 idle without start",
            int'({busy, acc_req}), 0);

        // Vector table walk: latency and stray-start variants
        for (int v = 0; v < NVEC; v++) run_seq(VEC_LAT[v], VEC_STRAY[v]);

        // R10: reset in mid-run, then a full fresh run
        clear_model(1);
        pulse_start();
        wait (nlog >= 30);
        @(negedge clk); #1 rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && acc_req == 1'b0, "R10 abort to idle",
            int'({busy, done, acc_req}), 0);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 stays idle after abort", int'(busy), 0);
        run_seq(1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule